// File: doc/BRIEF.md
# Flash Command Sequencer with Status Polling

This block sits in front of a small embedded flash array and turns plain bus writes into automatic byte-program and whole-array erase runs. Software never times a pulse and never verifies a result. To program a byte it writes a program set-up code and then a write that carries the target address and data. To erase the array it writes the erase code twice. The sequencer then runs pulse and verify steps on its own and retries a failed verify up to a parameter limit. The array is modelled as internal registers that reset to 0xFF. A program step can only clear bits. An erase first programs every location to 0x00, verifies each one, and then applies one erase pulse that returns every cell to 0xFF.

The bus uses active-low strobes `ce_n`, `we_n` and `oe_n`, which are sampled on `clk` and assumed synchronous to it. A write cycle is the span during which `ce_n` and `we_n` are both low. A read cycle is the span during which `ce_n` and `oe_n` are low and `we_n` is high. The bus has no back-pressure. A write that arrives while an operation runs is dropped, and software learns about progress only by reading.

While an operation runs, or after it has run out of retries, a read returns a status byte in place of array data. Bit 7 of that byte is the complement of bit 7 of the expected final data. Bit 6 flips on every read cycle. Bit 5 is the sticky failure flag. Bits 4 to 0 are zero.

Top module: `flash_seq`

## Requirements
- R1: After reset the array holds 0xFF at every address, the block is in read mode, and `rdata` is 0x00 until the first read cycle.
- R2: The write address is taken on the first clock at which `ce_n` and `we_n` are both low. Later changes of `addr` within the same write cycle have no effect.
- R3: The write data is taken on the first clock at which either `ce_n` or `we_n` is high again, and the command acts at that clock. Later changes of `wdata` have no effect.
- R4: A write of 0x40 followed by any write starts a program of the second write's address and data. The byte becomes old AND data. Each pulse-verify try takes PROG_PULSE+1 clocks.
- R5: A write of 0x20 followed by a second write of 0x20 starts an erase. The erase is busy for DEPTH*(PROG_PULSE+1)+ERASE_PULSE+1 clocks, and afterwards every byte reads 0xFF.
- R6: After 0x20, a second write other than 0x20 returns the block to read mode without changing the array. In read mode, a write other than 0x40 or 0x20 changes nothing.
- R7: In a status read, bit 7 is the complement of bit 7 of the expected final data. For a program that bit comes from the program data. For an erase it is 1.
- R8: In status mode, bit 6 inverts on every read cycle. Once an operation completes without failure, reads return array data again.
- R9: If a program verify still fails after PROG_TRIES tries, which is 25 by default, status bit 5 becomes 1. The erase verify uses ERASE_TRIES, which is 1000 by default.
- R10: The failure state stays until a write of 0xFF. Every other write in that state is ignored. After the 0xFF write, reads return array data.
- R11: Writes that complete while an operation is busy are ignored.
- R12: `rdata` changes only on the clock at which a read cycle starts. That clock captures either the array byte at `addr` or the status byte, and bits 4 to 0 of a status byte are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| addr | input | $clog2(DEPTH) | Byte address |
| wdata | input | 8 | Write data or command code |
| rdata | output | 8 | Read data or status byte, held between read cycles |

## Verification
A wrong state or a miscounted timer or retry counter does not show up until the next read cycle. Then it shows as a status byte where array data was expected, or array data where status was expected. This makes the exact clock at which busy ends visible with single-cycle precision. The bench therefore reads on the last busy clock and two clocks after it. A wrong address or data capture shows as a programmed byte at the wrong location or with the wrong value, which a read-back exposes as soon as the operation completes. A toggle or polling fault shows in bits 7 and 6 of the very next status read. The reference model compares `rdata` on every clock, so the first divergence is reported in the cycle it occurs.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] CMD_PROG_SETUP = 8'h40;
  localparam logic [DATA_W-1:0] CMD_ERASE      = 8'h20;
  localparam logic [DATA_W-1:0] CMD_RESET      = 8'hFF;

  typedef enum logic [3:0] {
    ST_READ,
    ST_SET_PROG,
    ST_SET_ERASE,
    ST_P_PULSE,
    ST_P_VFY,
    ST_PRE_PULSE,
    ST_PRE_VFY,
    ST_E_PULSE,
    ST_E_VFY,
    ST_FAILED
  } seq_state_e;

  typedef enum logic [1:0] {
    ARR_IDLE,
    ARR_PROG,
    ARR_ERASE
  } arr_op_e;

  // status byte: polling bit, toggle bit, failure bit, zeros
  function automatic logic [DATA_W-1:0] status_word(input logic exp7,
                                                    input logic tgl,
                                                    input logic fail);
    return {~exp7, tgl, fail, 5'b00000};
  endfunction

endpackage

// File: rtl/fseq_bus.sv
module fseq_bus #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  output logic          wr_end,
  output logic          rd_start,
  output logic [AW-1:0] wr_addr
);

  logic wr_act, rd_act;
  logic wr_q, rd_q;

  assign wr_act   = ~ce_n & ~we_n;
  assign rd_act   = ~ce_n & ~oe_n & we_n;
  assign wr_end   = wr_q & ~wr_act;
  assign rd_start = rd_act & ~rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_addr <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act && !wr_q) wr_addr <= addr;
    end
  end

endmodule

// File: rtl/fseq_array.sv
module fseq_array
  import flash_seq_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  arr_op_e           op,
  input  logic [AW-1:0]     op_addr,
  input  logic [DATA_W-1:0] op_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] vf_data,
  output logic              all_erased
);

  logic [DEPTH-1:0][DATA_W-1:0] cells;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '1;
      end else if (op == ARR_ERASE) begin
        q <= '1;
      end else if (op == ARR_PROG && op_addr == AW'(i)) begin
        q <= q & op_data;
      end
    end
    assign cells[i] = q;
  end

  assign rd_data = cells[rd_addr];
  assign vf_data = cells[op_addr];

  always_comb begin
    all_erased = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      if (cells[k] != '1) all_erased = 1'b0;
    end
  end

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int AW          = 8,
  parameter int PROG_PULSE  = 8,
  parameter int ERASE_PULSE = 64,
  parameter int PROG_TRIES  = 25,
  parameter int ERASE_TRIES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_end,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] vf_data,
  input  logic              all_erased,
  output arr_op_e           op,
  output logic [AW-1:0]     op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              busy,
  output logic              fail,
  output logic              exp7
);

  localparam int TMAX = (PROG_PULSE > ERASE_PULSE) ? PROG_PULSE : ERASE_PULSE;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RMAX = (PROG_TRIES > ERASE_TRIES) ? PROG_TRIES : ERASE_TRIES;
  localparam int RW   = $clog2(RMAX + 1);

  seq_state_e        state;
  logic [TW-1:0]     timer;
  logic [RW-1:0]     tries;
  logic [AW-1:0]     idx;
  logic [AW-1:0]     tgt_addr;
  logic [DATA_W-1:0] tgt_data;
  logic              pulse_done;
  logic              pre_phase;

  assign pulse_done = (timer == '0);
  assign pre_phase  = (state == ST_PRE_PULSE) || (state == ST_PRE_VFY);
  assign op_addr    = pre_phase ? idx : tgt_addr;
  assign op_data    = pre_phase ? '0 : tgt_data;
  assign busy       = state inside {ST_P_PULSE, ST_P_VFY, ST_PRE_PULSE,
                                    ST_PRE_VFY, ST_E_PULSE, ST_E_VFY};

  always_comb begin
    op = ARR_IDLE;
    unique case (state)
      ST_P_PULSE, ST_PRE_PULSE: if (pulse_done) op = ARR_PROG;
      ST_E_PULSE:               if (pulse_done) op = ARR_ERASE;
      default:                  op = ARR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_READ;
      timer    <= '0;
      tries    <= '0;
      idx      <= '0;
      tgt_addr <= '0;
      tgt_data <= '1;
      fail     <= 1'b0;
      exp7     <= 1'b1;
    end else begin
      unique case (state)
        ST_READ: begin
          if (wr_end) begin
            if (wr_data == CMD_PROG_SETUP)  state <= ST_SET_PROG;
            else if (wr_data == CMD_ERASE)  state <= ST_SET_ERASE;
          end
        end
        ST_SET_PROG: begin
          if (wr_end) begin
            tgt_addr <= wr_addr;
            tgt_data <= wr_data;
            exp7     <= wr_data[DATA_W-1];
            timer    <= TW'(PROG_PULSE - 1);
            tries    <= '0;
            state    <= ST_P_PULSE;
          end
        end
        ST_SET_ERASE: begin
          if (wr_end) begin
            if (wr_data == CMD_ERASE) begin
              exp7  <= 1'b1;
              idx   <= '0;
              timer <= TW'(PROG_PULSE - 1);
              tries <= '0;
              state <= ST_PRE_PULSE;
            end else begin
              state <= ST_READ;
            end
          end
        end
        ST_P_PULSE: begin
          if (pulse_done) state <= ST_P_VFY;
          else            timer <= timer - 1'b1;
        end
        ST_P_VFY: begin
          if (vf_data == tgt_data) begin
            state <= ST_READ;
          end else if (tries == RW'(PROG_TRIES - 1)) begin
            fail  <= 1'b1;
            state <= ST_FAILED;
          end else begin
            tries <= tries + 1'b1;
            timer <= TW'(PROG_PULSE - 1);
            state <= ST_P_PULSE;
          end
        end
        ST_PRE_PULSE: begin
          if (pulse_done) state <= ST_PRE_VFY;
          else            timer <= timer - 1'b1;
        end
        ST_PRE_VFY: begin
          if (vf_data == '0) begin
            tries <= '0;
            if (idx == AW'(DEPTH - 1)) begin
              timer <= TW'(ERASE_PULSE - 1);
              state <= ST_E_PULSE;
            end else begin
              idx   <= idx + 1'b1;
              timer <= TW'(PROG_PULSE - 1);
              state <= ST_PRE_PULSE;
            end
          end else if (tries == RW'(PROG_TRIES - 1)) begin
            fail  <= 1'b1;
            state <= ST_FAILED;
          end else begin
            tries <= tries + 1'b1;
            timer <= TW'(PROG_PULSE - 1);
            state <= ST_PRE_PULSE;
          end
        end
        ST_E_PULSE: begin
          if (pulse_done) state <= ST_E_VFY;
          else            timer <= timer - 1'b1;
        end
        ST_E_VFY: begin
          if (all_erased) begin
            state <= ST_READ;
          end else if (tries == RW'(ERASE_TRIES - 1)) begin
            fail  <= 1'b1;
            state <= ST_FAILED;
          end else begin
            tries <= tries + 1'b1;
            timer <= TW'(ERASE_PULSE - 1);
            state <= ST_E_PULSE;
          end
        end
        ST_FAILED: begin
          if (wr_end && wr_data == CMD_RESET) begin
            fail  <= 1'b0;
            state <= ST_READ;
          end
        end
        default: state <= ST_READ;
      endcase
    end
  end

endmodule

// File: rtl/fseq_rdpath.sv
module fseq_rdpath
  import flash_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic              busy,
  input  logic              fail,
  input  logic              exp7,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rdata,
  output logic              tgl
);

  logic status_mode;
  assign status_mode = busy | fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      tgl   <= 1'b0;
    end else if (rd_start) begin
      if (status_mode) begin
        tgl   <= ~tgl;
        rdata <= status_word(exp7, ~tgl, fail);
      end else begin
        rdata <= arr_data;
      end
    end
  end

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int PROG_PULSE  = 8,
  parameter int ERASE_PULSE = 64,
  parameter int PROG_TRIES  = 25,
  parameter int ERASE_TRIES = 1000,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic              wr_end, rd_start;
  logic [AW-1:0]     wr_addr;
  arr_op_e           op;
  logic [AW-1:0]     op_addr;
  logic [DATA_W-1:0] op_data;
  logic [DATA_W-1:0] arr_rd, vf_data;
  logic              all_erased;
  logic              busy, fail, exp7, tgl;

  fseq_bus #(.AW(AW)) u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wr_end(wr_end), .rd_start(rd_start), .wr_addr(wr_addr)
  );

  fseq_ctrl #(
    .DEPTH(DEPTH), .AW(AW), .PROG_PULSE(PROG_PULSE), .ERASE_PULSE(ERASE_PULSE),
    .PROG_TRIES(PROG_TRIES), .ERASE_TRIES(ERASE_TRIES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_end(wr_end), .wr_addr(wr_addr),
    .wr_data(wdata), .vf_data(vf_data), .all_erased(all_erased),
    .op(op), .op_addr(op_addr), .op_data(op_data),
    .busy(busy), .fail(fail), .exp7(exp7)
  );

  fseq_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .op(op), .op_addr(op_addr), .op_data(op_data),
    .rd_addr(addr), .rd_data(arr_rd), .vf_data(vf_data), .all_erased(all_erased)
  );

  fseq_rdpath u_rd (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .busy(busy), .fail(fail),
    .exp7(exp7), .arr_data(arr_rd), .rdata(rdata), .tgl(tgl)
  );

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       we_n,
  input logic       oe_n,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       busy,
  input logic       fail,
  input logic       tgl,
  input logic       exp7
);

  logic wr_q, rd_q, wr_act, rd_act, wr_end, rd_start;
  assign wr_act   = !ce_n && !we_n;
  assign rd_act   = !ce_n && !oe_n && we_n;
  assign wr_end   = wr_q && !wr_act;
  assign rd_start = rd_act && !rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
    end
  end

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start |=> $stable(rdata));

  p_status_low_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && (busy || fail)) |=> (rdata[4:0] == 5'b0));

  p_poll_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && busy) |=> (rdata[7] == !$past(exp7)));

  p_toggle_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && (busy || fail)) |=> (tgl != $past(tgl)));

  p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(wr_end && wdata == 8'hFF)) |=> fail);

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(exp7));

endmodule

bind flash_seq fseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .wdata(wdata), .rdata(rdata), .busy(busy), .fail(fail), .tgl(tgl), .exp7(exp7)
);

// File: tb/flash_seq_tb.sv
`timescale 1ns/1ps
module flash_seq_tb;

  localparam int N  = 256;
  localparam int PP = 8;
  localparam int EP = 64;
  localparam int PT = 25;
  localparam int D_PROG  = PP + 1;
  localparam int D_ERASE = N * (PP + 1) + EP + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;

  int    checks = 0, fails = 0;
  string phase = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  flash_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mem [N];
  int         m_mode;      // 0 read, 1 prog set-up, 2 erase set-up, 3 busy, 4 failed
  int         m_pre, m_left;
  bit         m_wq, m_rq, m_wa, m_ra, m_pend_fail, m_is_erase;
  logic       m_tgl, m_exp7;
  logic [7:0] m_rdata, m_lat, m_ta, m_td;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_mem[i] = 8'hFF;
      m_mode = 0; m_left = 0; m_wq = 0; m_rq = 0; m_tgl = 0; m_exp7 = 1;
      m_rdata = 8'h00; m_lat = 8'h00; m_pend_fail = 0; m_is_erase = 0;
      m_ta = 0; m_td = 8'hFF;
    end else begin
      m_wa  = !ce_n && !we_n;
      m_ra  = !ce_n && !oe_n && we_n;
      m_pre = m_mode;
      if (m_ra && !m_rq) begin
        if (m_pre == 3 || m_pre == 4) begin
          m_tgl   = !m_tgl;
          m_rdata = {!m_exp7, m_tgl, (m_pre == 4), 5'b00000};
        end else begin
          m_rdata = m_mem[addr];
        end
      end
      if (m_pre == 3) begin
        m_left--;
        if (m_left == 0) begin
          if (m_is_erase) for (int i = 0; i < N; i++) m_mem[i] = 8'hFF;
          else m_mem[m_ta] = m_mem[m_ta] & m_td;
          m_mode = m_pend_fail ? 4 : 0;
        end
      end
      if (!m_wa && m_wq) begin
        case (m_pre)
          0: if (wdata == 8'h40) m_mode = 1; else if (wdata == 8'h20) m_mode = 2;
          1: begin
            m_ta = m_lat; m_td = wdata; m_exp7 = wdata[7]; m_is_erase = 0;
            m_pend_fail = ((m_mem[m_lat] & wdata) != wdata);
            m_left = m_pend_fail ? PT * D_PROG : D_PROG;
            m_mode = 3;
          end
          2: begin
            if (wdata == 8'h20) begin
              m_exp7 = 1; m_is_erase = 1; m_pend_fail = 0;
              m_left = D_ERASE; m_mode = 3;
            end else m_mode = 0;
          end
          4: if (wdata == 8'hFF) m_mode = 0;
          default: ;
        endcase
      end
      if (m_wa && !m_wq) m_lat = addr;
      m_wq = m_wa;
      m_rq = m_ra;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rdata !== m_rdata) begin
        fails++;
        $display("FAIL %s per-cycle rdata actual %02h expected %02h", phase, rdata, m_rdata);
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk) addr = a; wdata = d; ce_n = 0; we_n = 0;
    @(negedge clk);
    @(negedge clk) we_n = 1;
    @(negedge clk) ce_n = 1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk) addr = a; ce_n = 0; oe_n = 0;
    @(negedge clk) v = rdata; ce_n = 1; oe_n = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R4 watchdog actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v1, v2;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 rdata after reset", rdata, 8'h00);
    rd(8'h05, v); chk("R1 erased byte", v, 8'hFF);
    rd(8'hFF, v); chk("R1 erased top byte", v, 8'hFF);

    // R4 / R7 / R8 / R12: program 0xA5 at 0x12
    phase = "R4";
    wr(8'h00, 8'h40); wr(8'h12, 8'hA5);
    rd(8'h12, v1); rd(8'h12, v2);
    chk("R7 polling bit while programming 0xA5", {7'b0, v1[7]}, 8'h00);
    chk("R12 status low bits zero", v1 & 8'h3F, 8'h00);
    chk("R8 toggle differs on consecutive reads", {7'b0, v1[6] ^ v2[6]}, 8'h01);
    idle(10);
    rd(8'h12, v); chk("R4 programmed byte", v, 8'hA5);
    rd(8'h12, v); chk("R8 no toggle after completion", v, 8'hA5);
    rd(8'h13, v); chk("R4 neighbour untouched", v, 8'hFF);

    // R4 timing: read on last busy clock is status, two clocks later is data
    wr(8'h00, 8'h40); wr(8'h60, 8'h7E);
    idle(D_PROG - 2);
    rd(8'h60, v); chk("R4 last busy clock gives status (bit7=~0)", v & 8'hBF, 8'h80);
    rd(8'h60, v); chk("R4 data right after busy", v, 8'h7E);

    // R6: abort and ignored commands
    phase = "R6";
    wr(8'h00, 8'h20); wr(8'h00, 8'h33);
    rd(8'h12, v); chk("R6 erase aborted, array kept", v, 8'hA5);
    wr(8'h12, 8'h00);
    rd(8'h12, v); chk("R6 plain write ignored in read mode", v, 8'hA5);

    // R2 / R3: ce_n falls first, we_n later; we_n rises first
    phase = "R2";
    wr(8'h00, 8'h40);
    @(negedge clk) ce_n = 0; addr = 8'h30; wdata = 8'h3C;
    @(negedge clk) we_n = 0; addr = 8'h31;
    @(negedge clk) addr = 8'h32;
    @(negedge clk) we_n = 1;
    @(negedge clk) wdata = 8'hC3;
    @(negedge clk) ce_n = 1;
    idle(12);
    rd(8'h31, v); chk("R2 R3 address at later fall, data at first rise", v, 8'h3C);
    rd(8'h30, v); chk("R2 early address ignored", v, 8'hFF);
    rd(8'h32, v); chk("R2 late address ignored", v, 8'hFF);
    // opposite strobe order
    wr(8'h00, 8'h40);
    @(negedge clk) we_n = 0; addr = 8'h40; wdata = 8'h0F;
    @(negedge clk) ce_n = 0; addr = 8'h41;
    @(negedge clk) addr = 8'h42;
    @(negedge clk) ce_n = 1;
    @(negedge clk) wdata = 8'hF0;
    @(negedge clk) we_n = 1;
    idle(12);
    rd(8'h41, v); chk("R3 ce_n-controlled write data", v, 8'h0F);
    rd(8'h42, v); chk("R2 ce_n-controlled late address ignored", v, 8'hFF);

    // R9 / R10: program 0x5A onto 0xA5 can never verify
    phase = "R9";
    wr(8'h00, 8'h40); wr(8'h12, 8'h5A);
    rd(8'h12, v); chk("R9 running status, fail clear, bit7=~0", v & 8'hBF, 8'h80);
    idle(PT * D_PROG + 10);
    rd(8'h12, v1); chk("R9 fail bit set after retries", v1 & 8'hBF, 8'hA0);
    phase = "R10";
    wr(8'h00, 8'h40);
    rd(8'h12, v2); chk("R10 fail sticky after other write", v2 & 8'hBF, 8'hA0);
    chk("R8 toggle still flips in fail state", {7'b0, v1[6] ^ v2[6]}, 8'h01);
    wr(8'h00, 8'hFF);
    rd(8'h12, v); chk("R10 reset command returns array data", v, 8'h00);

    // R11: writes during busy ignored
    phase = "R11";
    wr(8'h00, 8'h40); wr(8'h50, 8'h0F);
    wr(8'h00, 8'h20); wr(8'h00, 8'h20);
    idle(12);
    rd(8'h50, v); chk("R11 erase commands while busy ignored", v, 8'h0F);

    // R5: erase with exact busy length
    phase = "R5";
    wr(8'h00, 8'h20); wr(8'h00, 8'h20);
    rd(8'h12, v); chk("R7 erase polling bit is 0", v & 8'hBF, 8'h00);
    idle(D_ERASE - 4);
    rd(8'h12, v); chk("R5 last busy clock gives status", v & 8'hBF, 8'h00);
    rd(8'h12, v); chk("R5 erased byte", v, 8'hFF);
    rd(8'h50, v); chk("R5 erased byte 0x50", v, 8'hFF);
    rd(8'h31, v); chk("R5 erased byte 0x31", v, 8'hFF);

    idle(2);
    done = 1;
    summary();
    $finish;
  end

endmodule